// File: doc/BRIEF.md
# Four-Unit Register-Fed Datapath

This block is a small clocked datapath with four function units. All four run in parallel in every cycle. Each unit takes two operands from a shared pool of seven 16-bit two's-complement values and uses its own pair of operand addresses to pick them. The pool contains the external sample, the constants zero and one, and the four results that the units stored on the previous clock edge. Because of that, a unit can read its own earlier result as well as the results of the other three units.

Units 1, 2 and 3 each have one fixed operation: add, subtract and multiply. Unit 0 takes a two-bit opcode that selects a logical left shift, a bitwise XOR or an equality test. Each unit writes its result into its own register. The block output is the register of unit 3, so the output always shows the result of the previous cycle. The surrounding logic drives the addresses and the opcode directly in every cycle. There is no stored program.

Top module: `fu_quad_datapath`

## Requirements
- R1: Operand address encoding (3 bits) is 0 = ext_in, 1 = constant 0, 2 = constant 1, 3..6 = stored results of units 0..3. Address 7 selects constant 0.
- R2: Unit 1 stores left + right, wrapping modulo 2^16 with no saturation.
- R3: Unit 2 stores left - right, wrapping modulo 2^16.
- R4: Unit 3 stores the low 16 bits of left * right.
- R5: With op_sel = 2'b00, unit 0 stores left shifted logically left by the unsigned value of bits [4:0] of right. An amount of 16 to 31 gives 0.
- R6: With op_sel = 2'b01, unit 0 stores left XOR right.
- R7: With op_sel = 2'b10, unit 0 stores 1 when the operands are equal and 0 otherwise. op_sel = 2'b11 stores 0.
- R8: All four units compute from the pool as it stood before the edge, and all four registers load on the same edge. A unit that reads its own result sees the value from the previous cycle.
- R9: result_out is the register of unit 3. It changes only on a clock edge and shows the value computed from the inputs applied in the cycle before.
- R10: A synchronous active-high rst clears all four registers to 0, so result_out is 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 16 | External sample, pool entry 0 |
| op_sel | input | 2 | Operation of unit 0 (00 shift, 01 xor, 10 equal, 11 zero) |
| lhs_sel | input | 12 | Left operand addresses; bits [3u+2:3u] belong to unit u |
| rhs_sel | input | 12 | Right operand addresses; bits [3u+2:3u] belong to unit u |
| result_out | output | 16 | Stored result of unit 3 |

## Verification
The output register of unit 3 is loaded on the edge that samples the inputs, so it is the only direct view of the datapath, and its value is due one clock edge after the inputs are applied. The result of unit 0, 1 or 2 reaches the output after two edges: in the following cycle unit 3 multiplies that unit's register by the constant one. The bench drives its inputs on the falling edge, updates its reference model of all four registers at the rising edge, and compares at the next falling edge. Each comparison therefore sees exactly the registered value that the requirements predict.

// File: rtl/fu_quad_pkg.sv
package fu_quad_pkg;

   // Operation selector of the configurable unit (unit 0)
   typedef enum logic [1:0] {
      OPC_SHL  = 2'b00,
      OPC_XOR  = 2'b01,
      OPC_EQ   = 2'b10,
      OPC_ZERO = 2'b11
   } fu_opc_e;

   // Fixed operation kinds, chosen per unit by parameter
   localparam int KIND_MULTI = 0;
   localparam int KIND_ADD   = 1;
   localparam int KIND_SUB   = 2;
   localparam int KIND_MUL   = 3;

   // Pool layout: external sample, two constants, then unit results
   localparam int POOL_EXT   = 0;
   localparam int POOL_ZERO  = 1;
   localparam int POOL_ONE   = 2;
   localparam int POOL_FB0   = 3;

endpackage

// File: rtl/fu_operand_sel.sv
module fu_operand_sel #(
   parameter int DATA_W = 16,
   parameter int POOL_N = 7,
   parameter int ADDR_W = 3
) (
   input  logic [POOL_N-1:0][DATA_W-1:0] pool,
   input  logic [ADDR_W-1:0]             addr,
   output logic [DATA_W-1:0]             operand
);

   if ((1 << ADDR_W) < POOL_N) begin : g_bad_addr_w
      $error("fu_operand_sel: ADDR_W too narrow for the pool");
   end

   // Codes past the last pool entry fall through to zero
   always_comb begin
      operand = '0;
      for (int i = 0; i < POOL_N; i++) begin
         if (addr == ADDR_W'(i)) operand = pool[i];
      end
   end

endmodule

// File: rtl/fu_arith.sv
module fu_arith
   import fu_quad_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int KIND    = KIND_ADD
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] res
);

   // Two's-complement add, subtract and low-half multiply are
   // sign-agnostic, so plain vectors are used throughout.
   if (KIND == KIND_ADD) begin : g_add
      assign res = lhs + rhs;
   end else if (KIND == KIND_SUB) begin : g_sub
      assign res = lhs - rhs;
   end else if (KIND == KIND_MUL) begin : g_mul
      assign res = lhs * rhs;
   end else begin : g_bad_kind
      $error("fu_arith: KIND must be add, sub or mul");
      assign res = '0;
   end

endmodule

// File: rtl/fu_multi.sv
module fu_multi
   import fu_quad_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SHAMT_W = 5
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic [1:0]        opc,
   output logic [DATA_W-1:0] res
);

   localparam int AMT_LIMIT = DATA_W;

   if (SHAMT_W >= DATA_W || SHAMT_W < 1) begin : g_bad_shamt
      $error("fu_multi: SHAMT_W must lie in 1..DATA_W-1");
   end
   if ((1 << SHAMT_W) < AMT_LIMIT) begin : g_short_shamt
      $error("fu_multi: SHAMT_W cannot express a full shift");
   end

   logic [SHAMT_W-1:0] amt;
   logic [DATA_W-1:0]  shl_res;
   logic               unused_rhs_hi;

   assign amt           = rhs[SHAMT_W-1:0];
   assign unused_rhs_hi = ^rhs[DATA_W-1:SHAMT_W];

   // Logical left shift; amounts at or past the width flush to zero
   always_comb begin
      if (32'(amt) >= AMT_LIMIT) shl_res = '0;
      else                        shl_res = lhs << amt;
   end

   always_comb begin
      unique case (fu_opc_e'(opc))
         OPC_SHL:  res = shl_res;
         OPC_XOR:  res = lhs ^ rhs;
         OPC_EQ:   res = (lhs == rhs) ? DATA_W'(1) : '0;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/fu_quad_datapath.sv
module fu_quad_datapath
   import fu_quad_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int SHAMT_W   = 5,
   parameter int NUM_UNITS = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [DATA_W-1:0]             ext_in,
   input  logic [1:0]                    op_sel,
   input  logic [NUM_UNITS*ADDR_W-1:0]   lhs_sel,
   input  logic [NUM_UNITS*ADDR_W-1:0]   rhs_sel,
   output logic [DATA_W-1:0]             result_out
);

   localparam int POOL_N  = POOL_FB0 + NUM_UNITS;
   localparam int LAST_U  = NUM_UNITS - 1;

   if (NUM_UNITS != 4) begin : g_bad_units
      $error("fu_quad_datapath: exactly four units are supported");
   end
   if ((1 << ADDR_W) < POOL_N) begin : g_bad_addr
      $error("fu_quad_datapath: ADDR_W too narrow");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("fu_quad_datapath: DATA_W too small");
   end

   logic [NUM_UNITS-1:0][DATA_W-1:0] state_q;
   logic [NUM_UNITS-1:0][DATA_W-1:0] unit_res;
   logic [POOL_N-1:0][DATA_W-1:0]    pool;

   // Shared operand pool
   always_comb begin
      pool[POOL_EXT]  = ext_in;
      pool[POOL_ZERO] = '0;
      pool[POOL_ONE]  = DATA_W'(1);
      for (int u = 0; u < NUM_UNITS; u++) pool[POOL_FB0+u] = state_q[u];
   end

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic [DATA_W-1:0] opa, opb;

      fu_operand_sel #(.DATA_W(DATA_W), .POOL_N(POOL_N), .ADDR_W(ADDR_W)) u_sel_l (
         .pool    (pool),
         .addr    (lhs_sel[u*ADDR_W +: ADDR_W]),
         .operand (opa)
      );
      fu_operand_sel #(.DATA_W(DATA_W), .POOL_N(POOL_N), .ADDR_W(ADDR_W)) u_sel_r (
         .pool    (pool),
         .addr    (rhs_sel[u*ADDR_W +: ADDR_W]),
         .operand (opb)
      );

      if (u == 0) begin : g_cfg
         fu_multi #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_op (
            .lhs (opa),
            .rhs (opb),
            .opc (op_sel),
            .res (unit_res[u])
         );
      end else begin : g_fixed
         fu_arith #(.DATA_W(DATA_W), .KIND(u)) u_op (
            .lhs (opa),
            .rhs (opb),
            .res (unit_res[u])
         );
      end
   end

   // All unit registers load together
   always_ff @(posedge clk) begin
      if (rst) state_q <= '0;
      else     state_q <= unit_res;
   end

   assign result_out = state_q[LAST_U];

   // ---------------- assertions ----------------
   logic [ADDR_W-1:0] l0, r0, l1, r1, l2, r2, l3, r3;
   assign l0 = lhs_sel[0*ADDR_W +: ADDR_W];
   assign r0 = rhs_sel[0*ADDR_W +: ADDR_W];
   assign l1 = lhs_sel[1*ADDR_W +: ADDR_W];
   assign r1 = rhs_sel[1*ADDR_W +: ADDR_W];
   assign l2 = lhs_sel[2*ADDR_W +: ADDR_W];
   assign r2 = rhs_sel[2*ADDR_W +: ADDR_W];
   assign l3 = lhs_sel[3*ADDR_W +: ADDR_W];
   assign r3 = rhs_sel[3*ADDR_W +: ADDR_W];

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (state_q == '0 && result_out == '0));

   a_r7_equal_self: assert property (@(posedge clk) disable iff (rst)
      (op_sel == OPC_EQ && l0 == r0) |=> state_q[0] == DATA_W'(1));

   a_r7_code3_zero: assert property (@(posedge clk) disable iff (rst)
      (op_sel == OPC_ZERO) |=> state_q[0] == '0);

   a_r6_xor_self: assert property (@(posedge clk) disable iff (rst)
      (op_sel == OPC_XOR && l0 == r0) |=> state_q[0] == '0);

   a_r1_unused_code: assert property (@(posedge clk) disable iff (rst)
      (l2 == ADDR_W'(7) && r2 == ADDR_W'(POOL_ZERO)) |=> state_q[2] == '0);

   a_r2_one_plus_one: assert property (@(posedge clk) disable iff (rst)
      (l1 == ADDR_W'(POOL_ONE) && r1 == ADDR_W'(POOL_ONE)) |=> state_q[1] == DATA_W'(2));

   a_r9_out_follows: assert property (@(posedge clk) disable iff (rst)
      (l3 == ADDR_W'(POOL_ONE) && r3 == ADDR_W'(POOL_ONE)) |=> result_out == DATA_W'(1));

   a_r8_self_hold: assert property (@(posedge clk) disable iff (rst)
      (l3 == ADDR_W'(POOL_FB0 + 3) && r3 == ADDR_W'(POOL_ONE)) |=> $stable(result_out));

endmodule

// File: tb/fu_quad_datapath_test.sv
module fu_quad_datapath_test;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] ext_in;
   logic [1:0]  op_sel;
   logic [11:0] lhs_sel, rhs_sel;
   logic [15:0] result_out;

   int n_checks = 0;
   int n_fail   = 0;
   logic [15:0] m [4];

   always #10 clk = ~clk;   // 50 MHz

   fu_quad_datapath uut (
      .clk(clk), .rst(rst), .ext_in(ext_in), .op_sel(op_sel),
      .lhs_sel(lhs_sel), .rhs_sel(rhs_sel), .result_out(result_out)
   );

   function automatic logic [11:0] pk(input int a0, input int a1, input int a2, input int a3);
      return {3'(a3), 3'(a2), 3'(a1), 3'(a0)};
   endfunction

   function automatic logic [15:0] pool_val(input logic [2:0] a, input logic [15:0] x,
                                            input logic [15:0] s0, input logic [15:0] s1,
                                            input logic [15:0] s2, input logic [15:0] s3);
      case (a)
         3'd0: return x;
         3'd2: return 16'd1;
         3'd3: return s0;
         3'd4: return s1;
         3'd5: return s2;
         3'd6: return s3;
         default: return 16'd0;
      endcase
   endfunction

   function automatic logic [15:0] ref_multi(input logic [1:0] oc, input logic [15:0] a,
                                             input logic [15:0] b);
      int amt;
      amt = int'(b[4:0]);
      case (oc)
         2'b00: return (amt >= 16) ? 16'd0 : (a << amt);
         2'b01: return a ^ b;
         2'b10: return (a == b) ? 16'd1 : 16'd0;
         default: return 16'd0;
      endcase
   endfunction

   task automatic model_edge(input logic r, input logic [15:0] x, input logic [1:0] oc,
                             input logic [11:0] ls, input logic [11:0] rs);
      logic [15:0] a [4];
      logic [15:0] b [4];
      logic [31:0] prod;
      if (r) begin
         for (int u = 0; u < 4; u++) m[u] = 16'd0;
         return;
      end
      for (int u = 0; u < 4; u++) begin
         a[u] = pool_val(ls[3*u +: 3], x, m[0], m[1], m[2], m[3]);
         b[u] = pool_val(rs[3*u +: 3], x, m[0], m[1], m[2], m[3]);
      end
      prod = {16'd0, a[3]} * {16'd0, b[3]};
      m[0] = ref_multi(oc, a[0], b[0]);
      m[1] = a[1] + b[1];
      m[2] = a[2] - b[2];
      m[3] = prod[15:0];
   endtask

   // Called at a falling edge: drive, let the edge pass, compare at next fall
   task automatic step(input logic r, input logic [15:0] x, input logic [1:0] oc,
                       input logic [11:0] ls, input logic [11:0] rs, input string tag);
      rst = r; ext_in = x; op_sel = oc; lhs_sel = ls; rhs_sel = rs;
      @(posedge clk);
      model_edge(r, x, oc, ls, rs);
      @(negedge clk);
      n_checks++;
      if (result_out !== m[3]) begin
         n_fail++;
         $display("FAIL %s: result_out=%h expected %h", tag, result_out, m[3]);
      end
   endtask

   // route unit k's register to the output on the next edge (reg_k * 1)
   task automatic route(input int k, input string tag);
      step(1'b0, 16'd0, 2'b11, pk(1, 1, 1, 3 + k), pk(1, 1, 1, 2), tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd1234));
      rst = 1'b1; ext_in = '0; op_sel = '0; lhs_sel = '0; rhs_sel = '0;
      for (int u = 0; u < 4; u++) m[u] = 16'hxxxx;
      @(negedge clk);
      step(1'b1, 16'h1234, 2'b00, pk(0, 0, 0, 0), pk(0, 0, 0, 0), "R10 reset");

      // R2 add wrap: 0x7fff + 1
      step(1'b0, 16'h7fff, 2'b11, pk(1, 0, 1, 1), pk(1, 2, 1, 1), "R4");
      route(1, "R2 add wrap");
      // R3 subtract: 0 - 1
      step(1'b0, 16'h0000, 2'b11, pk(1, 1, 1, 1), pk(1, 1, 2, 1), "R4");
      route(2, "R3 subtract");
      step(1'b0, 16'h8000, 2'b11, pk(1, 1, 2, 1), pk(1, 1, 0, 1), "R4");
      route(2, "R3 subtract wrap");
      // R4 multiply keeps low half
      step(1'b0, 16'h0100, 2'b11, pk(1, 1, 1, 0), pk(1, 1, 1, 0), "R4 mul overflow");
      step(1'b0, 16'hfffd, 2'b11, pk(1, 1, 1, 0), pk(1, 1, 1, 0), "R4 mul negative");
      // R5 shift
      step(1'b0, 16'h0003, 2'b00, pk(0, 1, 1, 1), pk(0, 1, 1, 1), "R4");
      route(0, "R5 shift by 3");
      step(1'b0, 16'h0010, 2'b00, pk(0, 1, 1, 1), pk(0, 1, 1, 1), "R4");
      route(0, "R5 shift by 16");
      step(1'b0, 16'h0020, 2'b00, pk(0, 1, 1, 1), pk(0, 1, 1, 1), "R4");
      route(0, "R5 shift amount low bits zero");
      step(1'b0, 16'h8fff, 2'b00, pk(0, 1, 1, 1), pk(2, 1, 1, 1), "R4");
      route(0, "R5 shift out msb");
      // R6 xor
      step(1'b0, 16'h5a5a, 2'b01, pk(0, 1, 1, 1), pk(2, 1, 1, 1), "R4");
      route(0, "R6 xor");
      // R7 equal / code 11
      step(1'b0, 16'h0005, 2'b10, pk(1, 1, 1, 1), pk(1, 1, 1, 1), "R4");
      route(0, "R7 equal true");
      step(1'b0, 16'h0005, 2'b10, pk(0, 1, 1, 1), pk(2, 1, 1, 1), "R4");
      route(0, "R7 equal false");
      step(1'b0, 16'h0005, 2'b11, pk(0, 1, 1, 1), pk(0, 1, 1, 1), "R4");
      route(0, "R7 code 11 gives zero");
      // R1 address 7 and external input
      step(1'b0, 16'h4444, 2'b11, pk(1, 7, 1, 1), pk(1, 2, 1, 1), "R4");
      route(1, "R1 address 7 is zero");
      step(1'b0, 16'h4444, 2'b11, pk(1, 0, 1, 1), pk(1, 1, 1, 1), "R4");
      route(1, "R1 external input");
      // R8 feedback: unit1 increments itself while unit3 shows its old value
      for (int k = 0; k < 5; k++)
         step(1'b0, 16'h0000, 2'b11, pk(1, 4, 1, 4), pk(1, 2, 1, 2), "R8 feedback");
      // R9 one-cycle latency: output equals product of previous inputs
      step(1'b0, 16'h0007, 2'b11, pk(1, 1, 1, 0), pk(1, 1, 1, 2), "R9 latency");
      // R10 reset mid-run
      step(1'b1, 16'h7777, 2'b01, pk(0, 0, 0, 0), pk(2, 2, 2, 2), "R10 mid-run reset");

      // Constrained random traffic
      for (int n = 0; n < 600; n++) begin
         logic [15:0] x;
         logic [11:0] ls, rs;
         x  = 16'($urandom);
         if ($urandom_range(0, 3) == 0) x = 16'($urandom_range(0, 20));
         ls = 12'($urandom);
         rs = 12'($urandom);
         step(($urandom_range(0, 63) == 0), x, 2'($urandom), ls, rs, "R8 random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule